// File: doc/BRIEF.md
# DES Round Subkey Generator

This block feeds a DES round engine with its per-round 48-bit subkeys. The block takes a 64-bit key and drops the eight parity bits through the first key permutation, which leaves a 56-bit value. The block holds that value as two 28-bit halves. One subkey is presented at a time. On each advance strobe both halves rotate circularly by the amount the schedule gives for that round, and the second permutation picks 48 of the 56 rotated bits to form the next subkey.

A load strobe captures the key and the direction select, and the first subkey appears on the following cycle. In encrypt mode the subkeys come out in the order K1, K2, ... K16, with left rotations. In decrypt mode they come out as K16, K15, ... K1. Decrypt mode starts from the unrotated halves, because the rotations over all sixteen rounds add up to a full 28-bit turn. From there it rotates right, walking the schedule backwards. A valid flag and a delivery index let the round engine pace itself against the generator.

Top module: `des_key_sched`

## Requirements
- R1: After reset, valid_o is 0, round_o is 0 and subkey_o is 0.
- R2: A cycle with load_i high sets valid_o to 1 and round_o to 1 on the next cycle. In encrypt mode (decrypt_i = 0 at load) subkey_o then holds K1. Bit numbering counts bit 1 as the MSB of key_i and of subkey_o.
- R3: The key bits at positions 8, 16, 24, 32, 40, 48, 56 and 64 (bit 1 = MSB, that is key_i[56], [48], [40], [32], [24], [16], [8], [0]) have no effect on any subkey.
- R4: In encrypt mode, each cycle with adv_i high and valid_o high moves subkey_o from Kn to Kn+1 and increments round_o. The halves rotate left by 1 before rounds 1, 2, 9 and 16 and by 2 before every other round. For key 0x133457799BBCDFF1 this gives K1 = 0x1B02EFFC7072, K2 = 0x79AED9DBC9E5, K3 = 0x55FC8A42CF99 and K16 = 0xCB3D8B0E17F5.
- R5: In decrypt mode (decrypt_i = 1 at load) the n-th subkey delivered, with round_o = n, equals encrypt-mode K(17-n).
- R6: An advance taken while round_o is 16 clears valid_o and sets round_o to 0. subkey_o holds its last value, and any advance while valid_o is 0 changes nothing.
- R7: In a cycle with neither load_i nor an accepted advance, round_o, valid_o and subkey_o keep their values.
- R8: load_i wins over adv_i in the same cycle and restarts the sequence at round 1 from any point.
- R9: decrypt_i is sampled only in a load cycle. Changing it at any other time has no effect on the sequence.
- R10: An all-zero key gives all-zero subkeys, and an all-one key gives all-one subkeys, in every round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| key_i | input | 64 | Key with parity bits, bit 1 is the MSB |
| load_i | input | 1 | Capture the key and the direction, restart at round 1 |
| adv_i | input | 1 | Advance to the next subkey |
| decrypt_i | input | 1 | 1 = reverse order for decryption, sampled at load |
| subkey_o | output | 48 | Current round subkey |
| round_o | output | 5 | Delivery index 1..16, 0 when idle |
| valid_o | output | 1 | subkey_o is a member of the current sequence |

## Verification
A wrong rotation amount in any round corrupts that round's subkey on the cycle after the advance. Because the halves carry state forward, every later subkey in the sequence is wrong as well. So comparing K1, K2, K3 and K16 against a known key catches schedule errors at both ends of the sequence. A decrypt-direction or start-state fault shows on the first subkey after load, since it must equal encrypt K16. A fault in the mid-sequence right rotation shows by the 16th subkey at the latest, as a mismatch against the reversed encrypt sequence. Counter or flag faults show within one cycle on round_o and valid_o.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;

    localparam int unsigned KS_KEY_W   = 64;
    localparam int unsigned KS_CD_W    = 56;
    localparam int unsigned KS_HALF_W  = 28;
    localparam int unsigned KS_SUB_W   = 48;
    localparam int unsigned KS_ROUNDS  = 16;

    // Source bit (1 = MSB of the 64-bit key) for each 56-bit output position
    localparam int unsigned PC1_SRC [KS_CD_W] = '{
        57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
        10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
        63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
        14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
    };

    // Source bit (1 = MSB of the 56-bit rotated state) for each subkey bit
    localparam int unsigned PC2_SRC [KS_SUB_W] = '{
        14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
        23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
        41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
        44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
    };

    // Rotation applied before round r (1-based): single step at 1, 2, 9, 16
    function automatic logic [1:0] rot_amount(input int unsigned r);
        if (r == 1 || r == 2 || r == 9 || r == 16) return 2'd1;
        else                                       return 2'd2;
    endfunction

    typedef struct packed {
        logic [KS_HALF_W-1:0] c;
        logic [KS_HALF_W-1:0] d;
    } ks_halves_t;

endpackage

// File: rtl/des_ks_pc1.sv
module des_ks_pc1
    import des_ks_pkg::*;
#(
    parameter int unsigned KEY_W = KS_KEY_W,
    parameter int unsigned CD_W  = KS_CD_W
) (
    input  logic [KEY_W-1:0] key_i,
    output logic [CD_W-1:0]  cd_o
);
    // Pure wiring: output bit j (1 = MSB) takes key bit PC1_SRC[j-1]
    for (genvar j = 0; j < CD_W; j++) begin : g_map
        assign cd_o[CD_W-1-j] = key_i[KEY_W - PC1_SRC[j]];
    end
endmodule

// File: rtl/des_ks_pc2.sv
module des_ks_pc2
    import des_ks_pkg::*;
#(
    parameter int unsigned CD_W  = KS_CD_W,
    parameter int unsigned SUB_W = KS_SUB_W
) (
    input  logic [CD_W-1:0]  cd_i,
    output logic [SUB_W-1:0] sub_o
);
    for (genvar j = 0; j < SUB_W; j++) begin : g_map
        assign sub_o[SUB_W-1-j] = cd_i[CD_W - PC2_SRC[j]];
    end
endmodule

// File: rtl/des_ks_rot.sv
module des_ks_rot #(
    parameter int unsigned W     = 28,
    parameter int unsigned AMT_W = 2
) (
    input  logic [W-1:0]     in_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             left_i,
    output logic [W-1:0]     out_o
);
    localparam int unsigned DW = 2 * W;

    logic [DW-1:0] dbl;
    logic [DW-1:0] shl;
    logic [DW-1:0] shr;

    always_comb begin
        dbl   = {in_i, in_i};
        shl   = dbl << amt_i;
        shr   = dbl >> amt_i;
        out_o = left_i ? shl[DW-1:W] : shr[W-1:0];
    end
endmodule

// File: rtl/des_ks_ctrl.sv
module des_ks_ctrl
    import des_ks_pkg::*;
#(
    parameter int unsigned ROUNDS  = KS_ROUNDS,
    parameter int unsigned ROUND_W = $clog2(ROUNDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               adv_i,
    input  logic               decrypt_i,
    output logic [1:0]         amt_o,
    output logic               left_o,
    output logic [ROUND_W-1:0] round_o,
    output logic               valid_o
);
    typedef struct packed {
        logic [ROUND_W-1:0] round;
        logic               dec;
        logic               valid;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     step;

    always_comb begin
        st_d   = st_q;
        amt_o  = 2'd0;
        left_o = 1'b1;
        step   = adv_i && st_q.valid;
        if (load_i) begin
            st_d.round = ROUND_W'(1);
            st_d.valid = 1'b1;
            st_d.dec   = decrypt_i;
            // decrypt begins at the unrotated state (full turn = K16)
            amt_o      = decrypt_i ? 2'd0 : rot_amount(1);
        end else if (step) begin
            if (int'(st_q.round) == ROUNDS) begin
                st_d.round = '0;
                st_d.valid = 1'b0;
            end else begin
                st_d.round = st_q.round + ROUND_W'(1);
                if (st_q.dec) begin
                    left_o = 1'b0;
                    amt_o  = rot_amount(ROUNDS + 1 - int'(st_q.round));
                end else begin
                    amt_o  = rot_amount(int'(st_q.round) + 1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign round_o = st_q.round;
    assign valid_o = st_q.valid;

    p_load_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (round_o == ROUND_W'(1)) && valid_o);

    p_adv_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && valid_o && int'(round_o) < ROUNDS)
        |=> (round_o == $past(round_o) + ROUND_W'(1)) && valid_o);

    p_end_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && adv_i && valid_o && int'(round_o) == ROUNDS)
        |=> !valid_o && round_o == '0);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !(adv_i && valid_o)) |=> $stable(round_o) && $stable(valid_o));

    p_mode_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.dec));

    p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (round_o != '0 && int'(round_o) <= ROUNDS));
endmodule

// File: rtl/des_key_sched.sv
module des_key_sched
    import des_ks_pkg::*;
#(
    parameter int unsigned KEY_W   = KS_KEY_W,
    parameter int unsigned HALF_W  = KS_HALF_W,
    parameter int unsigned SUB_W   = KS_SUB_W,
    parameter int unsigned ROUNDS  = KS_ROUNDS,
    parameter int unsigned ROUND_W = $clog2(ROUNDS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [KEY_W-1:0]   key_i,
    input  logic               load_i,
    input  logic               adv_i,
    input  logic               decrypt_i,
    output logic [SUB_W-1:0]   subkey_o,
    output logic [ROUND_W-1:0] round_o,
    output logic               valid_o
);
    localparam int unsigned CD_W = 2 * HALF_W;

    logic [CD_W-1:0] pc1_cd;
    logic [1:0]      amt;
    logic            left;
    ks_halves_t      hv_d, hv_q;
    logic [HALF_W-1:0] rot_in  [2];
    logic [HALF_W-1:0] rot_out [2];

    des_ks_pc1 #(.KEY_W(KEY_W), .CD_W(CD_W)) u_pc1 (
        .key_i (key_i),
        .cd_o  (pc1_cd)
    );

    des_ks_ctrl #(.ROUNDS(ROUNDS), .ROUND_W(ROUND_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_i),
        .adv_i     (adv_i),
        .decrypt_i (decrypt_i),
        .amt_o     (amt),
        .left_o    (left),
        .round_o   (round_o),
        .valid_o   (valid_o)
    );

    // Rotator input: freshly permuted key on load, held halves otherwise
    always_comb begin
        rot_in[0] = load_i ? pc1_cd[CD_W-1:HALF_W] : hv_q.c;
        rot_in[1] = load_i ? pc1_cd[HALF_W-1:0]    : hv_q.d;
    end

    for (genvar h = 0; h < 2; h++) begin : g_half
        des_ks_rot #(.W(HALF_W), .AMT_W(2)) u_rot (
            .in_i   (rot_in[h]),
            .amt_i  (amt),
            .left_i (left),
            .out_o  (rot_out[h])
        );
    end

    always_comb begin
        hv_d   = hv_q;
        hv_d.c = rot_out[0];
        hv_d.d = rot_out[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hv_q <= '0;
        else        hv_q <= hv_d;
    end

    des_ks_pc2 #(.CD_W(CD_W), .SUB_W(SUB_W)) u_pc2 (
        .cd_i  ({hv_q.c, hv_q.d}),
        .sub_o (subkey_o)
    );

    p_hold_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && amt == 2'd0) |=> $stable(subkey_o));

    p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o && round_o == '0 && $past(!rst_n) |-> subkey_o == '0);
endmodule

// File: tb/des_key_sched_tb.sv
module des_key_sched_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] key_i = '0;
    logic        load_i = 1'b0;
    logic        adv_i = 1'b0;
    logic        decrypt_i = 1'b0;
    logic [47:0] subkey_o;
    logic [4:0]  round_o;
    logic        valid_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [63:0] VKEY = 64'h133457799BBCDFF1;
    localparam logic [47:0] VK1  = 48'h1B02EFFC7072;
    localparam logic [47:0] VK2  = 48'h79AED9DBC9E5;
    localparam logic [47:0] VK3  = 48'h55FC8A42CF99;
    localparam logic [47:0] VK16 = 48'hCB3D8B0E17F5;

    logic [47:0] enc_seq [17];

    always #10 clk = ~clk;   // 50 MHz

    des_key_sched u_dut (
        .clk(clk), .rst_n(rst_n), .key_i(key_i), .load_i(load_i),
        .adv_i(adv_i), .decrypt_i(decrypt_i),
        .subkey_o(subkey_o), .round_o(round_o), .valid_o(valid_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // inputs are set at a falling edge; one rising edge; sample at next falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        load_i = 1'b0;
        adv_i  = 1'b0;
    endtask

    task automatic do_load(input logic [63:0] k, input logic dec);
        key_i = k; decrypt_i = dec; load_i = 1'b1;
        cyc();
    endtask

    task automatic do_adv();
        adv_i = 1'b1;
        cyc();
    endtask

    task automatic t_reset();
        chk("R1 valid", 64'(valid_o), 64'd0);
        chk("R1 round", 64'(round_o), 64'd0);
        chk("R1 subkey", 64'(subkey_o), 64'd0);
    endtask

    task automatic t_encrypt_vector();
        do_load(VKEY, 1'b0);
        chk("R2 valid", 64'(valid_o), 64'd1);
        chk("R2 round", 64'(round_o), 64'd1);
        chk("R2 K1", 64'(subkey_o), 64'(VK1));
        enc_seq[1] = subkey_o;
        for (int r = 2; r <= 16; r++) begin
            do_adv();
            chk("R4 round", 64'(round_o), 64'(r));
            enc_seq[r] = subkey_o;
        end
        chk("R4 K2", 64'(enc_seq[2]), 64'(VK2));
        chk("R4 K3", 64'(enc_seq[3]), 64'(VK3));
        chk("R4 K16", 64'(enc_seq[16]), 64'(VK16));
        do_adv();
        chk("R6 valid drop", 64'(valid_o), 64'd0);
        chk("R6 round zero", 64'(round_o), 64'd0);
        chk("R6 subkey hold", 64'(subkey_o), 64'(VK16));
        do_adv();
        chk("R6 ignored adv", 64'(subkey_o), 64'(VK16));
        chk("R6 ignored adv valid", 64'(valid_o), 64'd0);
    endtask

    task automatic t_decrypt();
        do_load(VKEY, 1'b1);
        chk("R5 first", 64'(subkey_o), 64'(VK16));
        for (int n = 1; n <= 16; n++) begin
            if (n > 1) do_adv();
            chk("R5 round", 64'(round_o), 64'(n));
            chk("R5 reverse", 64'(subkey_o), 64'(enc_seq[17 - n]));
        end
        do_adv();
        chk("R6 decrypt end", 64'(valid_o), 64'd0);
    endtask

    task automatic t_parity();
        do_load(VKEY ^ 64'h0101010101010101, 1'b0);
        for (int r = 1; r <= 16; r++) begin
            if (r > 1) do_adv();
            chk("R3 parity ignored", 64'(subkey_o), 64'(enc_seq[r]));
        end
    endtask

    task automatic t_idle();
        do_load(VKEY, 1'b0);
        do_adv();
        for (int i = 0; i < 4; i++) cyc();
        chk("R7 hold subkey", 64'(subkey_o), 64'(VK2));
        chk("R7 hold round", 64'(round_o), 64'd2);
        chk("R7 hold valid", 64'(valid_o), 64'd1);
    endtask

    task automatic t_priority();
        do_load(VKEY, 1'b0);
        do_adv(); do_adv();
        key_i = VKEY; decrypt_i = 1'b0; load_i = 1'b1; adv_i = 1'b1;
        cyc();
        chk("R8 round", 64'(round_o), 64'd1);
        chk("R8 K1", 64'(subkey_o), 64'(VK1));
    endtask

    task automatic t_mode_sample();
        do_load(VKEY, 1'b0);
        decrypt_i = 1'b1;
        do_adv();
        chk("R9 K2 despite select", 64'(subkey_o), 64'(VK2));
        do_adv();
        chk("R9 K3 despite select", 64'(subkey_o), 64'(VK3));
        decrypt_i = 1'b0;
    endtask

    task automatic t_extremes();
        do_load('0, 1'b0);
        for (int r = 1; r <= 16; r++) begin
            if (r > 1) do_adv();
            chk("R10 zeros", 64'(subkey_o), 64'd0);
        end
        do_load('1, 1'b1);
        for (int r = 1; r <= 16; r++) begin
            if (r > 1) do_adv();
            chk("R10 ones", 64'(subkey_o), 64'(48'hFFFFFFFFFFFF));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_encrypt_vector();
        t_decrypt();
        t_parity();
        t_idle();
        t_priority();
        t_mode_sample();
        t_extremes();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule